// File: doc/BRIEF.md
# Flow-Through Burst Synchronous SRAM

This block is a cycle-accurate synthesizable model of a synchronous static memory. Each word holds 18 bits, arranged as two 9-bit byte lanes. All control inputs are sampled on the rising clock edge. Read data has no output register: the word at the address registered on an edge appears on the read bus during the cycle that follows that edge.

An access starts on one of two address strobes: the host strobe or the controller strobe. Once a burst is open, a 2-bit counter walks the low two address bits through four locations. It steps in exclusive-or order or in modulo-4 order, chosen by a static select. Both strobes high with the advance input low moves the burst one step. Both strobes high with advance high holds the burst at its current address. Writes can cover the whole word or selected byte lanes.

The data bus is split into a write bus, a read bus and a drive flag. The flag tells the pad logic outside the block when the read bus should be driven.

Top module: `fts_sram`

## Requirements
- R1: After a clocked reset, no burst is open and `rd_drive` is 0.
- R2: `hst_strb_n` low, `ce_main_n` low, `ce_hi` high and `ce_lo_n` low together open a read burst at `addr`. On that edge the write controls and `adv_n` have no effect: the array is not written.
- R3: `ctl_strb_n` low with `hst_strb_n` high opens a burst at `addr` when all three enables are active. The write controls are sampled on that same edge, so the access is a write when R7 calls for one and a read otherwise.
- R4: `ce_main_n` high turns the host strobe into a no-op; the open burst simply continues or holds. It does not block the controller strobe. Either strobe taking effect while an enable is inactive deselects the block, and `rd_drive` then stays 0 until a new burst opens.
- R5: With both strobes high and a burst open, `adv_n` low steps the burst offset by one. `adv_n` high holds the current address.
- R6: With `order_xor` = 1, the offset is start XOR count. With `order_xor` = 0, the offset is (start + count) mod 4. The count is 0..3 and wraps to 0 after 3. Address bits above bit 1 stay fixed during a burst.
- R7: `wr_all_n` low writes both lanes. Otherwise `wr_byte_n` low together with `lane_wr_n[i]` low writes lane i: lane 0 is bits 8:0 and lane 1 is bits 17:9. `lane_wr_n` = 2'b11, or `wr_byte_n` high, makes the access a read.
- R8: On edges after the opening edge, the lane enables are sampled. A write cycle stores `wr_data` at the address selected by that same edge. Writing also forces `rd_drive` to 0 whatever `oe_n` is. A write with `adv_n` low writes at the next burst address.
- R9: `rd_data` shows the word at the address selected by the latest edge, in the same cycle. `rd_drive` is 1 only when `oe_n` is low, a burst is open and the current access is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | AW | Word address for a new burst |
| ce_main_n | input | 1 | Master enable, active low; gates the host strobe |
| ce_hi | input | 1 | Chip enable, active high |
| ce_lo_n | input | 1 | Chip enable, active low |
| hst_strb_n | input | 1 | Host address strobe, active low, always opens a read |
| ctl_strb_n | input | 1 | Controller address strobe, active low, opens a read or a write |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Whole-word write, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_wr_n | input | 2 | Per-lane write enables, active low |
| order_xor | input | 1 | Burst order: 1 exclusive-or, 0 modulo-4 |
| oe_n | input | 1 | Output enable, active low, not clocked |
| wr_data | input | 18 | Write data |
| rd_data | output | 18 | Read data, flow-through |
| rd_drive | output | 1 | Read bus should be driven |

## Verification
The hardest cases to reach are those where the host strobe is held low while the master enable is high. The block must then ignore the strobe and continue or suspend the open burst. The stimulus for this opens a burst first, then holds the host strobe low with a foreign address. It then checks that the data still follows the burst rather than the new address.

Byte-lane writes inside a burst are also hard to reach, because they only count on edges after the opening edge. The bench opens a host-strobe read while the write inputs are active, and shows that this edge wrote nothing. It then issues an advancing write and a suspended single-lane write to the same location. Each result is read back through controller-strobe reads.

// File: rtl/fts_pkg.sv
// Shared types and helpers for the flow-through burst SRAM.
// Assumes a 2-bit burst field in the low address bits.
package fts_pkg;

    typedef enum logic [2:0] {
        OP_HOLD,   // no strobe, no open burst
        OP_DESEL,  // strobe taken with an enable inactive
        OP_START,  // new burst at the external address
        OP_ADV,    // step burst counter
        OP_SUSP    // keep the current address
    } op_e;

    // Burst offset from the start bits and the step count.
    function automatic logic [1:0] burst_off(input logic [1:0] base,
                                             input logic [1:0] cnt,
                                             input logic       xor_mode);
        return xor_mode ? (base ^ cnt) : (base + cnt);
    endfunction

endpackage

// File: rtl/fts_decode.sv
// Cycle decoder: turns strobes, enables, advance and write controls into
// one operation plus per-lane write enables for the current edge.
// Assumes inputs are already synchronous to clk; purely combinational.
module fts_decode
    import fts_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             ce_main_n,
    input  logic             ce_hi,
    input  logic             ce_lo_n,
    input  logic             hst_strb_n,
    input  logic             ctl_strb_n,
    input  logic             adv_n,
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic             act_q,
    output op_e              op,
    output logic [LANES-1:0] lane_we
);

    logic             sel;
    logic             hst_hit;
    logic [LANES-1:0] mask;

    // Selection and lane mask derived from the raw controls.
    always_comb begin
        sel     = !ce_main_n && ce_hi && !ce_lo_n;
        hst_hit = !hst_strb_n && !ce_main_n;
        if (!wr_all_n)       mask = '1;
        else if (!wr_byte_n) mask = ~lane_wr_n;
        else                 mask = '0;
    end

    // Priority: host strobe, then controller strobe, then burst continuation.
    always_comb begin
        op      = OP_HOLD;
        lane_we = '0;
        if (hst_hit) begin
            op = sel ? OP_START : OP_DESEL;
        end else if (!ctl_strb_n) begin
            op      = sel ? OP_START : OP_DESEL;
            lane_we = sel ? mask : '0;
        end else if (act_q) begin
            op      = adv_n ? OP_SUSP : OP_ADV;
            lane_we = mask;
        end
    end

endmodule

// File: rtl/fts_burst.sv
// Burst address unit: holds the registered start address and 2-bit count,
// and gives both the address in use now and the one the next edge selects.
// Assumes AW > 2; the order select is static during a burst.
module fts_burst
    import fts_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  op_e           op,
    input  logic [AW-1:0] addr,
    input  logic          order_xor,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] nxt_addr
);

    logic [AW-1:0] base_q, base_d;
    logic [1:0]    cnt_q, cnt_d;

    // Next start address and count for this edge.
    always_comb begin
        base_d = base_q;
        cnt_d  = cnt_q;
        if (op == OP_START) begin
            base_d = addr;
            cnt_d  = 2'd0;
        end else if (op == OP_ADV) begin
            cnt_d = cnt_q + 2'd1;
        end
    end

    // Present and next word addresses; upper bits come from the start.
    always_comb begin
        cur_addr = {base_q[AW-1:2], burst_off(base_q[1:0], cnt_q, order_xor)};
        nxt_addr = {base_d[AW-1:2], burst_off(base_d[1:0], cnt_d, order_xor)};
    end

    // Burst state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            base_q <= base_d;
            cnt_q  <= cnt_d;
        end
    end

    // R5: a suspend keeps the address unchanged.
    p_susp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SUSP) |=> $stable(cur_addr));

    // R5: an advance always moves to a different word.
    p_adv_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ADV) |=> (cur_addr != $past(cur_addr)));

    // R6: upper bits never move while a burst continues.
    p_upper_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ADV || op == OP_SUSP) |=> $stable(cur_addr[AW-1:2]));

endmodule

// File: rtl/fts_lane_ram.sv
// One byte lane of the array: a clocked write port and an asynchronous
// read port, so a read needs no output register.
// Assumes the contents are not reset.
module fts_lane_ram #(
    parameter int AW = 10,
    parameter int W  = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    localparam int DEPTH = 2 ** AW;

    logic [W-1:0] mem [DEPTH];

    // Store one lane on a write edge.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Flow-through read of the addressed word.
    always_comb rdata = mem[raddr];

endmodule

// File: rtl/fts_sram.sv
// Flow-through burst synchronous SRAM: decoder, burst address unit and
// one RAM per byte lane. Tracks an open-burst flag and a write flag so
// continuation cycles need no new strobe. Synchronous active-low reset.
module fts_sram
    import fts_pkg::*;
#(
    parameter int AW     = 10,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int DW    = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             ce_main_n,
    input  logic             ce_hi,
    input  logic             ce_lo_n,
    input  logic             hst_strb_n,
    input  logic             ctl_strb_n,
    input  logic             adv_n,
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic             order_xor,
    input  logic             oe_n,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    rd_data,
    output logic             rd_drive
);

    op_e              op;
    logic [LANES-1:0] lane_we;
    logic [AW-1:0]    cur_addr;
    logic [AW-1:0]    nxt_addr;
    logic             act_q;
    logic             wr_q;

    fts_decode #(.LANES(LANES)) u_decode (
        .ce_main_n (ce_main_n),
        .ce_hi     (ce_hi),
        .ce_lo_n   (ce_lo_n),
        .hst_strb_n(hst_strb_n),
        .ctl_strb_n(ctl_strb_n),
        .adv_n     (adv_n),
        .wr_all_n  (wr_all_n),
        .wr_byte_n (wr_byte_n),
        .lane_wr_n (lane_wr_n),
        .act_q     (act_q),
        .op        (op),
        .lane_we   (lane_we)
    );

    fts_burst #(.AW(AW)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .addr     (addr),
        .order_xor(order_xor),
        .cur_addr (cur_addr),
        .nxt_addr (nxt_addr)
    );

    genvar gi;
    generate
        for (gi = 0; gi < LANES; gi++) begin : g_lane
            fts_lane_ram #(.AW(AW), .W(LANE_W)) u_ram (
                .clk  (clk),
                .we   (lane_we[gi] && rst_n),
                .waddr(nxt_addr),
                .wdata(wr_data[gi*LANE_W +: LANE_W]),
                .raddr(cur_addr),
                .rdata(rd_data[gi*LANE_W +: LANE_W])
            );
        end
    endgenerate

    // Open-burst and write-cycle flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            wr_q  <= 1'b0;
        end else begin
            if (op == OP_START)      act_q <= 1'b1;
            else if (op == OP_DESEL) act_q <= 1'b0;
            if (op != OP_HOLD)       wr_q  <= |lane_we;
        end
    end

    // Drive only for a selected read with output enable low.
    always_comb rd_drive = !oe_n && act_q && !wr_q;

    // R2: a host-strobe start is always a read.
    p_host_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hst_strb_n && !ce_main_n && ce_hi && !ce_lo_n) |=> (act_q && !wr_q));

    // R4: controller strobe with master enable high deselects.
    p_ctl_desel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_main_n && !ctl_strb_n) |=> !rd_drive);

    // R7: a whole-word controller write is readable in the next cycle.
    p_word_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_strb_n && !ctl_strb_n && !ce_main_n && ce_hi && !ce_lo_n && !wr_all_n)
        |=> (rd_data == $past(wr_data)));

    // R8: a lane write inside a burst mutes the read bus.
    p_lane_mute_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && hst_strb_n && ctl_strb_n && !wr_byte_n && (lane_wr_n != '1))
        |=> !rd_drive);

endmodule

// File: tb/fts_sram_tb.sv
// Directed bench for fts_sram with a reference memory.
module fts_sram_tb;

    localparam int AW = 10;
    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          ce_main_n, ce_hi, ce_lo_n;
    logic          hst_strb_n, ctl_strb_n, adv_n;
    logic          wr_all_n, wr_byte_n;
    logic [1:0]    lane_wr_n;
    logic          order_xor, oe_n;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] rd_data;
    logic          rd_drive;

    logic [DW-1:0] ref_mem [2**AW];
    int            checks = 0;
    int            errors = 0;

    always #10 clk = ~clk;

    fts_sram #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_main_n(ce_main_n),
        .ce_hi(ce_hi), .ce_lo_n(ce_lo_n), .hst_strb_n(hst_strb_n),
        .ctl_strb_n(ctl_strb_n), .adv_n(adv_n), .wr_all_n(wr_all_n),
        .wr_byte_n(wr_byte_n), .lane_wr_n(lane_wr_n), .order_xor(order_xor),
        .oe_n(oe_n), .wr_data(wr_data), .rd_data(rd_data), .rd_drive(rd_drive)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_in();
        ce_main_n = 0; ce_hi = 1; ce_lo_n = 0;
        hst_strb_n = 1; ctl_strb_n = 1; adv_n = 1;
        wr_all_n = 1; wr_byte_n = 1; lane_wr_n = 2'b11;
        oe_n = 0; wr_data = '0;
    endtask

    task automatic ctl_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        ctl_strb_n = 0; addr = a; wr_all_n = 0; wr_data = d;
        step();
        ref_mem[a] = d;
        idle_in();
    endtask

    task automatic ctl_read(input string req, input logic [AW-1:0] a);
        ctl_strb_n = 0; addr = a;
        step();
        idle_in();
        chk(req, rd_data, ref_mem[a]);
        chk(req, {17'd0, rd_drive}, 18'd1);
    endtask

    task automatic t_reset();
        idle_in(); addr = '0; order_xor = 1; rst_n = 0;
        repeat (3) step();
        rst_n = 1;
        step();
        chk("R1 no drive after reset", {17'd0, rd_drive}, 18'd0);
    endtask

    task automatic t_fill();
        for (int a = 0; a < 48; a++) begin
            ctl_write(AW'(a), DW'(a * 4099 + 17));
            chk("R3 controller write mutes drive", {17'd0, rd_drive}, 18'd0);
        end
        ctl_read("R3 controller read", 10'd5);
    endtask

    task automatic t_host_ignores_write();
        hst_strb_n = 0; addr = 10'd6; wr_all_n = 0; wr_byte_n = 0;
        lane_wr_n = 2'b00; adv_n = 0; wr_data = 18'h2AAAA;
        step();
        idle_in();
        chk("R2 host start reads external address", rd_data, ref_mem[6]);
        chk("R9 host read drives", {17'd0, rd_drive}, 18'd1);
        ctl_read("R2 array unchanged after host start", 10'd6);
    endtask

    task automatic t_burst(input logic xm, input logic [AW-1:0] a);
        string tag;
        order_xor = xm;
        tag = xm ? "R6 xor order" : "R6 linear order";
        hst_strb_n = 0; addr = a;
        step();
        idle_in();
        chk("R9 flow-through first word", rd_data, ref_mem[a]);
        for (int k = 1; k <= 4; k++) begin
            logic [1:0] off;
            adv_n = 0;
            step();
            adv_n = 1;
            off = xm ? (a[1:0] ^ 2'(k)) : (a[1:0] + 2'(k));
            chk(tag, rd_data, ref_mem[{a[AW-1:2], off}]);
        end
        step();
        off_check: begin
            logic [1:0] o4;
            o4 = a[1:0];
            chk("R5 suspend holds address", rd_data, ref_mem[{a[AW-1:2], o4}]);
        end
    endtask

    task automatic t_oe();
        hst_strb_n = 0; addr = 10'd13;
        step();
        idle_in();
        oe_n = 1;
        #1;
        chk("R9 oe high stops drive", {17'd0, rd_drive}, 18'd0);
        chk("R9 data still flows", rd_data, ref_mem[13]);
        oe_n = 0;
    endtask

    task automatic t_lanes();
        logic [DW-1:0] e;
        ctl_strb_n = 0; addr = 10'd20; wr_byte_n = 0; lane_wr_n = 2'b10;
        wr_data = 18'h3FFFF;
        step();
        idle_in();
        chk("R7 lane write mutes drive", {17'd0, rd_drive}, 18'd0);
        e = {ref_mem[20][17:9], 9'h1FF};
        ref_mem[20] = e;
        ctl_read("R7 lane 0 only written", 10'd20);
        ctl_strb_n = 0; addr = 10'd21; wr_byte_n = 0; lane_wr_n = 2'b11;
        wr_data = 18'h15555;
        step();
        idle_in();
        chk("R7 no lane selected is a read", {17'd0, rd_drive}, 18'd1);
        chk("R7 no lane selected keeps data", rd_data, ref_mem[21]);
        ctl_strb_n = 0; addr = 10'd22; wr_byte_n = 1; lane_wr_n = 2'b00;
        wr_data = 18'h15555;
        step();
        idle_in();
        chk("R7 byte enable high is a read", rd_data, ref_mem[22]);
    endtask

    task automatic t_burst_write();
        order_xor = 0;
        hst_strb_n = 0; addr = 10'd24;
        step();
        idle_in();
        wr_byte_n = 0; lane_wr_n = 2'b00; adv_n = 0; wr_data = 18'h1C3A5;
        step();
        ref_mem[25] = 18'h1C3A5;
        chk("R8 burst write mutes drive", {17'd0, rd_drive}, 18'd0);
        chk("R8 advancing write lands on next word", rd_data, ref_mem[25]);
        adv_n = 1; lane_wr_n = 2'b01; wr_data = 18'h2B0F0;
        step();
        ref_mem[25] = {9'h158, ref_mem[25][8:0]};
        chk("R8 suspended lane 1 write", rd_data, ref_mem[25]);
        lane_wr_n = 2'b11; wr_byte_n = 1; adv_n = 0;
        step();
        idle_in();
        chk("R8 read resumes in burst", rd_data, ref_mem[26]);
        chk("R8 read resumes drive", {17'd0, rd_drive}, 18'd1);
        ctl_read("R8 written word readback", 10'd25);
        ctl_read("R8 unwritten neighbour", 10'd24);
    endtask

    task automatic t_master();
        order_xor = 0;
        hst_strb_n = 0; addr = 10'd8;
        step();
        ce_main_n = 1; addr = 10'd40;
        step();
        chk("R4 blocked host strobe suspends", rd_data, ref_mem[8]);
        chk("R4 blocked host strobe keeps drive", {17'd0, rd_drive}, 18'd1);
        adv_n = 0;
        step();
        chk("R4 blocked host strobe advances", rd_data, ref_mem[9]);
        adv_n = 1; hst_strb_n = 1; ctl_strb_n = 0;
        step();
        chk("R4 controller strobe deselects", {17'd0, rd_drive}, 18'd0);
        idle_in(); adv_n = 0;
        step();
        chk("R4 advance after deselect no drive", {17'd0, rd_drive}, 18'd0);
        idle_in();
        ctl_read("R4 controller start after deselect", 10'd3);
        ce_hi = 0; hst_strb_n = 0; addr = 10'd4;
        step();
        idle_in();
        chk("R4 inactive enable deselects", {17'd0, rd_drive}, 18'd0);
    endtask

    initial begin
        idle_in(); addr = '0; order_xor = 1; rst_n = 0;
        @(negedge clk);
        t_reset();
        t_fill();
        t_host_ignores_write();
        t_burst(1'b1, 10'd6);
        t_burst(1'b0, 10'd14);
        t_burst(1'b1, 10'd33);
        t_oe();
        t_lanes();
        t_burst_write();
        t_master();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (all): actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule